// File: doc/BRIEF.md
# Configuration Sequencing Controller

The controller takes a programmable-logic fabric from reset to user mode in a fixed order of eight phases. When the active-low configuration reset is released, it first reads every word of a small fuse array through a one-word read port and latches the words into holding registers. It then writes zeros to configuration memory, one frame per cycle, through a frame-wide write port. Neither phase needs any bitstream input. A busy output stays high from reset until the last clearing write. Only after that does the controller look at the byte-wide bitstream.

In the bitstream the controller hunts for a 32-bit sync word at any byte alignment and then checks a 32-bit device identifier. Next comes a header word that gives the frame count. The controller writes the frames that follow to incrementing frame addresses. It then compares a CRC-32 of the frame bytes with a trailing word, counts out a short startup delay and raises a done output. Any failed check stops the sequence with an error flag set, and only a reset leaves that state.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low: `phase_o`=0, `cfg_busy_o`=1, `done_o`=0, `err_o`=0, `frm_we_o`=0, and all latched fuse bits read 0.
- R2: In the cycles right after reset release, `fuse_rd_o` is high for NUM_FUSE cycles, with `fuse_addr_o` counting 0 to NUM_FUSE-1, one address per cycle. The word read at address k is latched into `fuse_bits_o[k*FUSE_W +: FUSE_W]` and holds until the next reset.
- R3: The clear phase begins in the cycle after the last fuse read. It issues NUM_FRAMES writes in consecutive cycles, with frame addresses 0 to NUM_FRAMES-1 in order and all-zero data.
- R4: `cfg_busy_o` stays high through the cycle of the last clear write. It falls in the next cycle and does not rise again before reset.
- R5: Bytes presented before `cfg_busy_o` falls have no effect. After it falls, bytes are discarded until the last four bytes received, read first byte as most significant, equal SYNC_WORD, at any byte alignment.
- R6: The 32-bit word after the sync word (first byte most significant) must equal DEVICE_ID. On a mismatch, `err_o` rises and stays high, no later write or done occurs, and `phase_o` keeps the value of the phase that failed.
- R7: The next word is the frame count. A count of 0 or greater than NUM_FRAMES sets the error as in R6.
- R8: Each frame is FRAME_WORDS words, sent first byte most significant. Word k of a frame occupies `frm_wdata_o[32*k +: 32]`. A frame is written at frame addresses 0, 1, 2 and so on, with the write in the cycle after the frame's last byte is accepted.
- R9: The trailer word must equal the CRC-32 of all frame bytes in arrival order: reflected polynomial 0xEDB88320, initial value all ones, result inverted. On a mismatch the error is set and `done_o` never rises.
- R10: After a good trailer, the startup phase lasts STARTUP_CYC cycles. Then `done_o` rises and stays high until reset, and later bytes cause no writes.
- R11: `phase_o` encodes 0 reset, 1 fuse read, 2 clear, 3 sync and ID, 4 header and frame load, 5 CRC, 6 startup, 7 user mode.
- R12: Asserting `rst_ni` at any point abandons the sequence, zeroes the fuse latches and restarts from the fuse-read phase on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous configuration reset |
| fuse_rd_o | output | 1 | Fuse read strobe |
| fuse_addr_o | output | FUSE_AW | Fuse word address |
| fuse_data_i | input | FUSE_W | Fuse word, valid in the same cycle as its address |
| fuse_bits_o | output | NUM_FUSE*FUSE_W | Latched fuse words |
| frm_we_o | output | 1 | Frame write enable |
| frm_addr_o | output | FRAME_AW | Frame address |
| frm_wdata_o | output | 32*FRAME_WORDS | Frame write data |
| cfg_busy_o | output | 1 | High while not ready for a bitstream |
| bs_valid_i | input | 1 | Bitstream byte valid |
| bs_byte_i | input | 8 | Bitstream byte |
| phase_o | output | 3 | Current phase code |
| err_o | output | 1 | Sequence failed |
| done_o | output | 1 | User mode reached |

## Verification
The assertions assume that the fuse array returns its word combinationally in the same cycle as `fuse_addr_o`. They also assume that `rst_ni` is low from time zero, so the write and phase history they look back on starts from a defined state. The bench models the fuse array as a combinational lookup. It holds reset low before every run. It changes `bs_valid_i` and `bs_byte_i` only on falling edges, including the sync bytes it sends while the clear phase is still running, so every byte is taken at a single rising edge.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_FUSE, ST_CLEAR, ST_SYNC, ST_ID, ST_HDR,
    ST_LOAD, ST_CRC, ST_START, ST_USER, ST_ERR
  } cfg_state_e;

  // reflected CRC-32, one byte
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [2:0] phase_of(input cfg_state_e s);
    case (s)
      ST_FUSE:          return 3'd1;
      ST_CLEAR:         return 3'd2;
      ST_SYNC, ST_ID:   return 3'd3;
      ST_HDR, ST_LOAD:  return 3'd4;
      ST_CRC:           return 3'd5;
      ST_START:         return 3'd6;
      ST_USER:          return 3'd7;
      default:          return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_byte_packer.sv
module cfg_byte_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] window_o,
  output logic        word_vld_o
);
  logic [23:0] sr_q;
  logic [1:0]  cnt_q;

  assign window_o   = {sr_q, byte_i};
  assign word_vld_o = en_i && (cnt_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sr_q  <= window_o[23:0];
      cnt_q <= cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/cfg_crc32.sv
module cfg_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  import cfg_seq_pkg::*;
  logic [31:0] crc_q;

  assign crc_o = ~crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (en_i)  crc_q <= crc32_step(crc_q, byte_i);
  end
endmodule

// File: rtl/cfg_fuse_latch.sv
module cfg_fuse_latch #(
  parameter int NUM_FUSE = 4,
  parameter int FUSE_W   = 16,
  parameter int IDX_W    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [FUSE_W-1:0]          data_i,
  output logic [NUM_FUSE*FUSE_W-1:0] fuses_o
);
  for (genvar k = 0; k < NUM_FUSE; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                fuses_o[k*FUSE_W +: FUSE_W] <= '0;
      else if (en_i && idx_i == IDX_W'(k))        fuses_o[k*FUSE_W +: FUSE_W] <= data_i;
    end
  end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl #(
  parameter int          NUM_FUSE    = 4,
  parameter int          FUSE_W      = 16,
  parameter int          NUM_FRAMES  = 8,
  parameter int          FRAME_WORDS = 2,
  parameter int          STARTUP_CYC = 5,
  parameter logic [31:0] SYNC_WORD   = 32'hA55A_3CC3,
  parameter logic [31:0] DEVICE_ID   = 32'h0D15_E220,
  localparam int FUSE_AW  = (NUM_FUSE > 1) ? $clog2(NUM_FUSE) : 1,
  localparam int FRAME_AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int FRAME_W  = 32 * FRAME_WORDS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  output logic                       fuse_rd_o,
  output logic [FUSE_AW-1:0]         fuse_addr_o,
  input  logic [FUSE_W-1:0]          fuse_data_i,
  output logic [NUM_FUSE*FUSE_W-1:0] fuse_bits_o,
  output logic                       frm_we_o,
  output logic [FRAME_AW-1:0]        frm_addr_o,
  output logic [FRAME_W-1:0]         frm_wdata_o,
  output logic                       cfg_busy_o,
  input  logic                       bs_valid_i,
  input  logic [7:0]                 bs_byte_i,
  output logic [2:0]                 phase_o,
  output logic                       err_o,
  output logic                       done_o
);
  import cfg_seq_pkg::*;

  localparam int WORD_AW  = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam int START_W  = $clog2(STARTUP_CYC + 1);

  cfg_state_e state_q, state_d;
  logic [FUSE_AW-1:0]  fidx_q;
  logic [FRAME_AW-1:0] cidx_q, ld_addr_q, ld_waddr_q;
  logic [FRAME_AW:0]   nfr_q;
  logic [WORD_AW-1:0]  widx_q;
  logic [FRAME_W-1:0]  frame_buf_q, frame_nxt, ld_data_q;
  logic                ld_we_q;
  logic [START_W-1:0]  st_cnt_q;
  logic [2:0]          err_phase_q;

  logic        rx_state, accept, sync_hit, word_vld, last_word, last_frame;
  logic [31:0] window, crc_val;

  assign rx_state = state_q inside {ST_SYNC, ST_ID, ST_HDR, ST_LOAD, ST_CRC};
  assign accept   = rx_state && bs_valid_i;
  assign sync_hit = (state_q == ST_SYNC) && accept && (window == SYNC_WORD);

  cfg_byte_packer u_packer (
    .clk_i, .rst_ni,
    .clr_i     (!rx_state || sync_hit),
    .en_i      (accept),
    .byte_i    (bs_byte_i),
    .window_o  (window),
    .word_vld_o(word_vld)
  );

  cfg_crc32 u_crc (
    .clk_i, .rst_ni,
    .clr_i (state_q == ST_HDR),
    .en_i  ((state_q == ST_LOAD) && accept),
    .byte_i(bs_byte_i),
    .crc_o (crc_val)
  );

  cfg_fuse_latch #(.NUM_FUSE(NUM_FUSE), .FUSE_W(FUSE_W), .IDX_W(FUSE_AW)) u_fuse (
    .clk_i, .rst_ni,
    .en_i   (state_q == ST_FUSE),
    .idx_i  (fidx_q),
    .data_i (fuse_data_i),
    .fuses_o(fuse_bits_o)
  );

  assign last_word  = (widx_q == WORD_AW'(FRAME_WORDS - 1));
  assign last_frame = ({1'b0, ld_addr_q} == nfr_q - 1'b1);

  always_comb begin
    frame_nxt = frame_buf_q;
    for (int k = 0; k < FRAME_WORDS; k++)
      if (widx_q == WORD_AW'(k)) frame_nxt[32*k +: 32] = window;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RST:   state_d = ST_FUSE;
      ST_FUSE:  if (fidx_q == FUSE_AW'(NUM_FUSE - 1)) state_d = ST_CLEAR;
      ST_CLEAR: if (cidx_q == FRAME_AW'(NUM_FRAMES - 1)) state_d = ST_SYNC;
      ST_SYNC:  if (sync_hit) state_d = ST_ID;
      ST_ID:    if (word_vld) state_d = (window == DEVICE_ID) ? ST_HDR : ST_ERR;
      ST_HDR:   if (word_vld)
                  state_d = (window != '0 && window <= 32'(NUM_FRAMES)) ? ST_LOAD : ST_ERR;
      ST_LOAD:  if (word_vld && last_word && last_frame) state_d = ST_CRC;
      ST_CRC:   if (word_vld) state_d = (window == crc_val) ? ST_START : ST_ERR;
      ST_START: if (st_cnt_q == START_W'(STARTUP_CYC - 1)) state_d = ST_USER;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RST;
      fidx_q      <= '0;
      cidx_q      <= '0;
      ld_addr_q   <= '0;
      ld_waddr_q  <= '0;
      nfr_q       <= '0;
      widx_q      <= '0;
      frame_buf_q <= '0;
      ld_data_q   <= '0;
      ld_we_q     <= 1'b0;
      st_cnt_q    <= '0;
      err_phase_q <= '0;
    end else begin
      state_q <= state_d;
      ld_we_q <= 1'b0;
      if (state_q == ST_FUSE)  fidx_q <= fidx_q + 1'b1;
      if (state_q == ST_CLEAR) cidx_q <= cidx_q + 1'b1;
      if (state_q == ST_HDR && word_vld) begin
        nfr_q     <= window[FRAME_AW:0];
        ld_addr_q <= '0;
        widx_q    <= '0;
      end
      if (state_q == ST_LOAD && word_vld) begin
        frame_buf_q <= frame_nxt;
        if (last_word) begin
          widx_q     <= '0;
          ld_we_q    <= 1'b1;
          ld_waddr_q <= ld_addr_q;
          ld_data_q  <= frame_nxt;
          ld_addr_q  <= ld_addr_q + 1'b1;
        end else begin
          widx_q <= widx_q + 1'b1;
        end
      end
      st_cnt_q <= (state_q == ST_START) ? st_cnt_q + 1'b1 : '0;
      if (state_d == ST_ERR && state_q != ST_ERR) err_phase_q <= phase_of(state_q);
    end
  end

  assign fuse_rd_o   = (state_q == ST_FUSE);
  assign fuse_addr_o = fidx_q;
  assign frm_we_o    = (state_q == ST_CLEAR) || ld_we_q;
  assign frm_addr_o  = (state_q == ST_CLEAR) ? cidx_q : ld_waddr_q;
  assign frm_wdata_o = (state_q == ST_CLEAR) ? '0 : ld_data_q;
  assign cfg_busy_o  = state_q inside {ST_RST, ST_FUSE, ST_CLEAR};
  assign err_o       = (state_q == ST_ERR);
  assign done_o      = (state_q == ST_USER);
  assign phase_o     = err_o ? err_phase_q : phase_of(state_q);

  // fuse reads walk the array one word per cycle
  assert_fuse_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_rd_o && $past(fuse_rd_o) |-> fuse_addr_o == $past(fuse_addr_o) + 1'b1);
  assert_fuse_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 3'd1 |=> $stable(fuse_bits_o));
  assert_clear_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_busy_o && frm_we_o |-> frm_wdata_o == '0);
  assert_busy_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_busy_o) |-> $past(frm_we_o) && $past(frm_addr_o) == FRAME_AW'(NUM_FRAMES - 1));
  assert_busy_no_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_busy_o |=> !cfg_busy_o);
  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && !done_o && !frm_we_o && $stable(phase_o));
  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !frm_we_o && !err_o);
endmodule

// File: tb/cfg_seq_ctrl_tb.sv
module cfg_seq_ctrl_tb;
  localparam int          NF    = 4;
  localparam int          FW    = 16;
  localparam int          NFR   = 8;
  localparam int          FWORD = 2;
  localparam int          SCYC  = 5;
  localparam logic [31:0] SYNC  = 32'hA55A_3CC3;
  localparam logic [31:0] DID   = 32'h0D15_E220;
  localparam int          FRW   = 32 * FWORD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fuse_rd, frm_we, busy, bs_valid = 1'b0, err, done;
  logic [1:0] fuse_addr;
  logic [2:0] frm_addr, phase;
  logic [FW-1:0] fuse_data;
  logic [NF*FW-1:0] fuse_bits;
  logic [FRW-1:0] frm_wdata;
  logic [7:0] bs_byte = '0;

  logic [FW-1:0] fuse_mem [NF];
  assign fuse_data = fuse_mem[fuse_addr];

  int checks = 0, fails = 0;
  logic [31:0] crc_acc;
  logic [2:0]     exp_addr_q[$];
  logic [FRW-1:0] exp_data_q[$];
  string          exp_tag_q[$];

  always #5 clk = ~clk;

  cfg_seq_ctrl #(.NUM_FUSE(NF), .FUSE_W(FW), .NUM_FRAMES(NFR), .FRAME_WORDS(FWORD),
                 .STARTUP_CYC(SCYC), .SYNC_WORD(SYNC), .DEVICE_ID(DID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fuse_rd_o(fuse_rd), .fuse_addr_o(fuse_addr),
    .fuse_data_i(fuse_data), .fuse_bits_o(fuse_bits), .frm_we_o(frm_we),
    .frm_addr_o(frm_addr), .frm_wdata_o(frm_wdata), .cfg_busy_o(busy),
    .bs_valid_i(bs_valid), .bs_byte_i(bs_byte), .phase_o(phase), .err_o(err), .done_o(done));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frm_we) begin
      if (exp_addr_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8/R10 unexpected write actual=%0h expected=none", frm_addr);
      end else begin
        string t = exp_tag_q.pop_front();
        chk({t, " addr"}, 64'(frm_addr), 64'(exp_addr_q.pop_front()));
        chk({t, " data"}, 64'(frm_wdata), 64'(exp_data_q.pop_front()));
      end
    end
  end

  task automatic push_write(input string tag, input int a, input logic [FRW-1:0] d);
    exp_tag_q.push_back(tag);
    exp_addr_q.push_back(3'(a));
    exp_data_q.push_back(d);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bs_valid = 1'b1; bs_byte = b;
    @(negedge clk);
    bs_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input bit in_load);
    for (int i = 3; i >= 0; i--) begin
      if (in_load) crc_acc = tb_crc(crc_acc, w[8*i +: 8]);
      send_byte(w[8*i +: 8]);
    end
  endtask

  function automatic logic [31:0] fword(input int t, input int f, input int k);
    return 32'hF000_0000 | 32'(t << 16) | 32'(f << 4) | 32'(k);
  endfunction

  task automatic send_frames(input int t, input int n);
    crc_acc = '1;
    for (int f = 0; f < n; f++) begin
      logic [FRW-1:0] d;
      for (int k = 0; k < FWORD; k++) d[32*k +: 32] = fword(t, f, k);
      push_write("R8 frame", f, d);
      for (int k = 0; k < FWORD; k++) send_word(fword(t, f, k), 1'b1);
    end
  endtask

  task automatic boot(input bit sync_in_clear);
    logic [NF*FW-1:0] exp_f;
    bs_valid = 1'b0;
    rst_n = 1'b0;
    exp_addr_q.delete(); exp_data_q.delete(); exp_tag_q.delete();
    repeat (3) @(negedge clk);
    chk("R1 phase", 64'(phase), 0);
    chk("R1 busy", 64'(busy), 1);
    chk("R1 done/err/we", 64'({done, err, frm_we}), 0);
    chk("R1 fuses", 64'(fuse_bits), 0);
    for (int f = 0; f < NFR; f++) push_write("R3 clear", f, '0);
    rst_n = 1'b1;
    for (int k = 0; k < NF; k++) begin
      @(negedge clk);
      chk("R2 fuse rd", 64'(fuse_rd), 1);
      chk("R2 fuse addr", 64'(fuse_addr), 64'(k));
      if (k == 0) chk("R11 phase fuse", 64'(phase), 1);
    end
    for (int f = 0; f < NFR; f++) begin
      @(negedge clk);
      chk("R4 busy during clear", 64'(busy), 1);
      if (f == 0) chk("R11 phase clear", 64'(phase), 2);
      bs_valid = sync_in_clear && f < 4;
      bs_byte  = SYNC[8*(3-(f%4)) +: 8];
    end
    @(negedge clk);
    bs_valid = 1'b0;
    chk("R4 busy released", 64'(busy), 0);
    chk("R11 phase sync", 64'(phase), 3);
    for (int k = 0; k < NF; k++) exp_f[k*FW +: FW] = fuse_mem[k];
    chk("R2 fuses latched", 64'(fuse_bits), 64'(exp_f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fuse_mem[0] = 16'hBEEF; fuse_mem[1] = 16'h1234;
    fuse_mem[2] = 16'h0000; fuse_mem[3] = 16'h8001;

    // T1: full boot, sync sent during clear must be ignored
    boot(1'b1);
    send_word(DID, 1'b0);
    chk("R5 early sync ignored", 64'(phase), 3);
    send_byte(8'hA5); send_byte(8'h5A); send_byte(8'h3C); send_byte(8'h00); send_byte(8'h77);
    chk("R5 partial sync", 64'(phase), 3);
    send_word(SYNC, 1'b0);
    chk("R5 sync odd alignment", 64'(phase), 3);
    send_word(DID, 1'b0);
    chk("R11 phase header", 64'(phase), 4);
    send_word(32'(NFR), 1'b0);
    send_frames(1, NFR);
    chk("R11 phase crc", 64'(phase), 5);
    send_word(~crc_acc, 1'b0);
    for (int i = 0; i < SCYC; i++) begin
      chk("R10 startup not done", 64'({done, phase}), 64'({1'b0, 3'd6}));
      @(negedge clk);
    end
    chk("R10 done", 64'(done), 1);
    chk("R11 phase user", 64'(phase), 7);
    send_word(SYNC, 1'b0); send_word(DID, 1'b0); send_word(32'h1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 done held", 64'({done, err}), 64'(2'b10));
    chk("R8 all frames written", 64'(exp_addr_q.size()), 0);

    // T2: reset in mid-load, then wrong device ID
    boot(1'b0);
    send_word(SYNC, 1'b0); send_word(DID, 1'b0); send_word(32'd2, 1'b0);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 fuses cleared", 64'(fuse_bits), 0);
    chk("R12 phase reset", 64'(phase), 0);
    boot(1'b0);
    send_word(SYNC, 1'b0); send_word(DID ^ 32'h100, 1'b0);
    chk("R6 id error", 64'({err, done}), 64'(2'b10));
    chk("R6 phase frozen", 64'(phase), 3);
    send_word(SYNC, 1'b0); send_word(DID, 1'b0);
    chk("R6 error held", 64'({err, phase}), 64'({1'b1, 3'd3}));

    // T3/T4: illegal frame counts
    boot(1'b0);
    send_word(SYNC, 1'b0); send_word(DID, 1'b0); send_word(32'd0, 1'b0);
    chk("R7 zero count", 64'({err, phase}), 64'({1'b1, 3'd4}));
    boot(1'b0);
    send_word(SYNC, 1'b0); send_word(DID, 1'b0); send_word(32'(NFR + 1), 1'b0);
    chk("R7 count too big", 64'({err, phase}), 64'({1'b1, 3'd4}));

    // T5: one frame, bad CRC
    boot(1'b0);
    send_word(SYNC, 1'b0); send_word(DID, 1'b0); send_word(32'd1, 1'b0);
    send_frames(5, 1);
    send_word(~crc_acc ^ 32'h1, 1'b0);
    chk("R9 crc error", 64'({err, phase}), 64'({1'b1, 3'd5}));
    repeat (SCYC + 4) @(negedge clk);
    chk("R9 no done", 64'(done), 0);
    chk("R8 single frame written", 64'(exp_addr_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule